// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block holds the alarm setting of a time-of-day clock and watches the running time for it. Software writes the alarm setting one byte at a time. There are four byte-wide fields: tenths of a second, seconds, minutes, and hours with an AM/PM bit. Each field has its own write strobe. A separate counter supplies the 24-bit live time. The block compares all 24 bits of that time against the alarm setting on every clock.

When the time first becomes equal to the alarm, the block produces a one-clock interrupt pulse and sets a sticky flag, which stays set until it is cleared. The comparator does not read the alarm registers directly. It reads a holding copy that refreshes only while no write strobe is active. Because of this, a multi-byte update never shows a half-written alarm value to the comparator. An equality that persists raises only one interrupt.

Top module: `tod_alarm_match`

## Requirements
- R1: Field writes and bit layout. Strobe bit 0 writes `wr_data[3:0]` into alarm bits [3:0] (tenths). Strobe bit 1 writes `wr_data[6:0]` into bits [10:4] (seconds). Strobe bit 2 writes `wr_data[6:0]` into bits [17:11] (minutes). `time_val` uses the same layout, and data bits above a field's width are ignored.
- R2: While `rst` is high, on every rising clock edge:
  - all alarm bits and their holding copy clear to 0;
  - `irq` and `flag` clear to 0;
  - `match` reads 1.
- R3: `match` is registered. It is 1 exactly when all 24 bits of `time_val` equal the held alarm value, and it reflects `time_val` one clock after it is applied.
- R4: While any strobe is high, the comparator keeps using the previous held alarm value. A written value first reaches the comparator at the clock edge after the strobes have gone low, so `match` reflects it two clocks after the strobe is released.
- R5: A 0-to-1 transition of `match` raises `irq` for exactly one clock, on the clock after `match` rises.
- R6: While `match` stays 1, no further `irq` is raised. A new pulse needs `match` to return to 0 first.
- R7: `flag` sets together with `irq` and stays set until `flag_clr` is sampled high with no coincident new rise. It then reads 0 on the next clock.
- R8: If `flag_clr` is high in the same cycle that a rise of `match` is being detected, `flag` stays set.
- R9: After reset, a time and alarm that are both zero produce no interrupt and leave `flag` at 0.
- R10: Strobe bit 3 writes the hours field. `wr_data[4:0]` goes to alarm bits [22:18] and `wr_data[7]` (PM) goes to bit 23. `wr_data[6:5]` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_val | input | 24 | Live time, same bit layout as the alarm |
| wr_data | input | 8 | Byte written into the selected alarm field |
| wr_strobe | input | 4 | One-hot field write enables: tenths, seconds, minutes, hours |
| flag_clr | input | 1 | Clears the sticky alarm flag |
| match | output | 1 | Registered equality of time and held alarm |
| irq | output | 1 | One-clock alarm interrupt pulse |
| flag | output | 1 | Sticky alarm flag |

## Verification
The properties assume that `rst` is high from time zero for at least one edge. They also assume that `wr_strobe` carries at most one active bit in any cycle.

The stimulus keeps to these assumptions in three ways:
- It asserts reset before any other activity.
- It writes the fields one strobe at a time.
- It changes `time_val`, `wr_data` and the strobes only on falling clock edges.

The stimulus also holds a strobe across several cycles to show that the held alarm stays frozen.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int NUM_FIELDS = 4;
  localparam int BUS_W      = 8;

  // Width of each alarm field: tenths, seconds, minutes, hours+PM
  function automatic int field_w(input int idx);
    case (idx)
      0:       return 4;
      1:       return 7;
      2:       return 7;
      default: return 6;
    endcase
  endfunction

  // Low bit position of a field inside the packed time word
  function automatic int field_lo(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += field_w(k);
    return acc;
  endfunction

  localparam int TIME_W = field_lo(NUM_FIELDS);
endpackage

// File: rtl/alarm_field_regs.sv
module alarm_field_regs #(
  parameter int NUM_FIELDS = tod_alarm_pkg::NUM_FIELDS,
  parameter int BUS_W      = tod_alarm_pkg::BUS_W,
  parameter int TIME_W     = tod_alarm_pkg::TIME_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [NUM_FIELDS-1:0] wr_strobe,
  output logic [TIME_W-1:0]     alarm_hold
);
  logic [TIME_W-1:0] alarm_live;
  logic              any_write;

  assign any_write = |wr_strobe;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int W  = tod_alarm_pkg::field_w(g);
    localparam int LO = tod_alarm_pkg::field_lo(g);
    logic [W-1:0] fld_q;
    logic [W-1:0] fld_d;

    if (g == NUM_FIELDS-1) begin : g_hours
      // top data bit carries the PM marker, the rest is the BCD hour
      assign fld_d = {wr_data[BUS_W-1], wr_data[W-2:0]};
    end else begin : g_plain
      assign fld_d = wr_data[W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)               fld_q <= '0;
      else if (wr_strobe[g]) fld_q <= fld_d;
    end

    assign alarm_live[LO+W-1:LO] = fld_q;
  end

  // Holding copy: refreshed only when no field is being written
  always_ff @(posedge clk) begin
    if (rst)             alarm_hold <= '0;
    else if (!any_write) alarm_hold <= alarm_live;
  end
endmodule

// File: rtl/alarm_eq_cmp.sv
module alarm_eq_cmp #(
  parameter int TIME_W = tod_alarm_pkg::TIME_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] time_val,
  input  logic [TIME_W-1:0] alarm_val,
  output logic              match_q
);
  logic [TIME_W-1:0] diff_bits;

  assign diff_bits = time_val ^ alarm_val;

  // Reset value 1 pairs with the edge detector's history reset
  always_ff @(posedge clk) begin
    if (rst) match_q <= 1'b1;
    else     match_q <= ~|diff_bits;
  end
endmodule

// File: rtl/alarm_irq_edge.sv
module alarm_irq_edge (
  input  logic clk,
  input  logic rst,
  input  logic match,
  input  logic flag_clr,
  output logic irq_q,
  output logic flag_q
);
  logic prev_q;
  logic rise;

  assign rise = match & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      irq_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= match;
      irq_q  <= rise;
      if (rise)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match #(
  parameter int NUM_FIELDS = tod_alarm_pkg::NUM_FIELDS,
  parameter int BUS_W      = tod_alarm_pkg::BUS_W,
  parameter int TIME_W     = tod_alarm_pkg::TIME_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TIME_W-1:0]     time_val,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic [NUM_FIELDS-1:0] wr_strobe,
  input  logic                  flag_clr,
  output logic                  match,
  output logic                  irq,
  output logic                  flag
);
  logic [TIME_W-1:0] alarm_hold;

  alarm_field_regs #(
    .NUM_FIELDS(NUM_FIELDS),
    .BUS_W     (BUS_W),
    .TIME_W    (TIME_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (wr_data),
    .wr_strobe (wr_strobe),
    .alarm_hold(alarm_hold)
  );

  alarm_eq_cmp #(
    .TIME_W(TIME_W)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .time_val (time_val),
    .alarm_val(alarm_hold),
    .match_q  (match)
  );

  alarm_irq_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .match   (match),
    .flag_clr(flag_clr),
    .irq_q   (irq),
    .flag_q  (flag)
  );
endmodule

// File: rtl/tod_alarm_match_chk.sv
module tod_alarm_match_chk #(
  parameter int NUM_FIELDS = tod_alarm_pkg::NUM_FIELDS,
  parameter int TIME_W     = tod_alarm_pkg::TIME_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_FIELDS-1:0] wr_strobe,
  input logic                  flag_clr,
  input logic                  match,
  input logic                  irq,
  input logic                  flag,
  input logic [TIME_W-1:0]     alarm_hold
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (!irq && !flag && match)); // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst) (|wr_strobe) |=> $stable(alarm_hold)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) irq |=> !irq); // R5
  AST_IRQ_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst) irq |-> $past(match)); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst) ($past(match) && $past(match, 2)) |-> !irq); // R6
  AST_FLAG_WITH_IRQ: assert property (@(posedge clk) disable iff (rst) irq |-> flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (flag && !flag_clr) |=> flag); // R7
  AST_CLEAR_OR_SET: assert property (@(posedge clk) disable iff (rst) flag_clr |=> (!flag || irq)); // R8
endmodule

bind tod_alarm_match tod_alarm_match_chk #(
  .NUM_FIELDS(NUM_FIELDS),
  .TIME_W    (TIME_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_strobe (wr_strobe),
  .flag_clr  (flag_clr),
  .match     (match),
  .irq       (irq),
  .flag      (flag),
  .alarm_hold(alarm_hold)
);

// File: tb/tod_alarm_match_tb.sv
`timescale 1ns/1ps
module tod_alarm_match_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] time_val = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  wr_strobe = '0;
  logic        flag_clr = 1'b0;
  logic        match, irq, flag;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tod_alarm_match u_dut (
    .clk(clk), .rst(rst), .time_val(time_val), .wr_data(wr_data),
    .wr_strobe(wr_strobe), .flag_clr(flag_clr),
    .match(match), .irq(irq), .flag(flag)
  );

  // {alarm bytes hr,min,sec,ten ; time bytes hr,min,sec,ten ; expected match}
  localparam bit [64:0] VEC [7] = '{
    {32'h92_30_15_05, 32'h92_30_15_05, 1'b1},  // R1 full equality, PM set
    {32'h92_30_15_05, 32'h92_30_15_06, 1'b0},  // R1 tenths differ
    {32'h00_00_00_00, 32'h00_00_00_00, 1'b1},  // R1 all zero
    {32'h92_59_59_09, 32'h12_59_59_09, 1'b0},  // R10 PM bit differs
    {32'hD1_07_45_03, 32'h91_07_45_03, 1'b1},  // R10 hours bit 6 ignored
    {32'h11_34_12_A3, 32'h11_34_12_03, 1'b1},  // R1 tenths upper nibble ignored
    {32'h00_00_40_01, 32'h00_00_00_01, 1'b0}   // R1 seconds bit 6 compared
  };

  function automatic logic [23:0] pack_time(input logic [31:0] b);
    return {b[31], b[28:24], b[22:16], b[14:8], b[3:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_alarm(input logic [31:0] b);
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      wr_data   = b[8*f +: 8];
      wr_strobe = 4'b0001 << f;
    end
    @(negedge clk);
    wr_strobe = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
  endtask

  initial begin
    // R2 reset state
    tick(2);
    chk("R2 match in reset", match, 1);
    chk("R2 irq in reset", irq, 0);
    chk("R2 flag in reset", flag, 0);
    rst = 1'b0;
    // R9 zeros after reset: no interrupt
    for (int i = 0; i < 5; i++) begin
      tick(1);
      chk("R9 no irq on zero", irq, 0);
    end
    chk("R9 flag still clear", flag, 0);

    // R1 / R10 / R3 vector table
    foreach (VEC[i]) begin
      write_alarm(VEC[i][64:33]);
      time_val = pack_time(VEC[i][32:1]);
      tick(3);
      chk($sformatf("R1 vector %0d match", i), match, VEC[i][0]);
    end

    // R2 alarm registers cleared by reset
    write_alarm(32'h92_30_15_05);
    time_val = pack_time(32'h92_30_15_05);
    tick(3);
    chk("R3 match before reset", match, 1);
    do_reset();
    tick(2);
    chk("R2 alarm cleared: old time mismatch", match, 0);
    time_val = '0;
    tick(1);
    chk("R3 zero time matches cleared alarm", match, 1);

    // R4 holding stage
    write_alarm(32'h92_30_15_05);
    time_val = pack_time(32'h92_30_15_05);
    tick(3);
    chk("R4 baseline match", match, 1);
    wr_data   = 8'h06;
    wr_strobe = 4'b0001;
    for (int i = 0; i < 3; i++) begin
      tick(1);
      chk("R4 match held while strobe high", match, 1);
    end
    wr_strobe = '0;
    tick(1);
    chk("R4 one clock after release still old", match, 1);
    tick(1);
    chk("R4 new alarm visible", match, 0);

    // R5/R6/R7 interrupt sequence, alarm now tenths=6
    do_reset();
    write_alarm(32'h92_30_15_06);
    time_val = pack_time(32'h92_30_15_05);
    tick(3);
    chk("R5 no match before", match, 0);
    time_val = pack_time(32'h92_30_15_06);
    tick(1);
    chk("R3 match one clock after time", match, 1);
    chk("R5 irq not yet", irq, 0);
    tick(1);
    chk("R5 irq pulse", irq, 1);
    chk("R7 flag set with irq", flag, 1);
    tick(1);
    chk("R5 irq one clock only", irq, 0);
    for (int i = 0; i < 4; i++) begin
      tick(1);
      chk("R6 no retrigger on level", irq, 0);
    end
    chk("R7 flag sticky", flag, 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R7 flag cleared", flag, 0);

    // R6 new rise after a gap; R8 clear coincident with rise
    time_val = pack_time(32'h92_30_15_05);
    tick(2);
    chk("R6 match dropped", match, 0);
    time_val = pack_time(32'h92_30_15_06);
    tick(1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R6 second irq after gap", irq, 1);
    chk("R8 flag kept despite clear", flag, 1);
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
    chk("R7 later clear works", flag, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule